// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the register front end of an eight-line programmable interrupt controller. A host drives single-byte writes and reads at two addresses. Address 0 carries three kinds of command, told apart by bits 4 and 3 of the written byte: the opening initialization word, a read/poll control word, and an end-of-interrupt or rotation word. Address 1 is steered by an initialization state machine. Once the sequence is complete, a write at address 1 loads the interrupt mask.

The block stores the mask, the in-service bits, the vector base, the mode flags and the rotation offset. Request capture and priority arithmetic sit outside it. The request register and two priority results come in as inputs: the best eligible request line and the best in-service line. The block drives clear vectors for request and in-service bits in the same cycle as the strobe. An external acknowledge path sets in-service bits through the `isr_set` input. Every command takes effect at the clock edge that ends its strobe cycle.

The initialization machine has four states. `ST_READY` (0) is normal operation. `ST_WAIT_BASE` (1) waits for the vector base word. `ST_WAIT_CASCADE` (2) waits for the cascade wiring word, which is discarded. `ST_WAIT_MODE` (3) waits for the mode word. The transitions are:
- Start: any state goes to `ST_WAIT_BASE` on an opening word.
- Base: `ST_WAIT_BASE` goes to `ST_WAIT_CASCADE` in cascade mode. In single mode it goes to `ST_WAIT_MODE` when a mode word is expected, otherwise to `ST_READY`.
- Cascade: `ST_WAIT_CASCADE` goes to `ST_WAIT_MODE` or `ST_READY`, depending on the mode-word flag.
- Mode: `ST_WAIT_MODE` goes to `ST_READY`.

Top module: `picseq_top`

## Requirements
- R1: After reset, `init_state` is 0 and the mask, in-service, vector base, rotation offset and all mode flags read 0.
- R2: An address-0 write with bit 4 set has these effects:
  - In the strobe cycle it drives `req_clr` to 0xFF and pulses `out_drop`.
  - It clears the mask, in-service, vector base, rotation offset and mode flags.
  - It sets `init_state` to 1.
  - It captures bit 0 as `need_mode_word` and bit 1 as `single_mode`.
  - It sets `level_err` to bit 3.
- R3: In state 1, an address-1 write sets `vec_base` to the byte AND 0xF8. The next state is 2 when `single_mode` is 0. When `single_mode` is 1, the next state is 3 if `need_mode_word` is 1, otherwise 0.
- R4: In state 2, an address-1 write changes no register. The next state is 3 if `need_mode_word` is 1, otherwise 0.
- R5: In state 3, an address-1 write sets `sfn_mode` to bit 4 and `auto_eoi` to bit 1, and the next state is 0.
- R6: In state 0, an address-1 write loads the whole byte into the mask.
- R7: An address-0 write with bit 4 clear and bit 3 set is a read/poll word with three independent fields:
  - Bit 2 set arms poll.
  - When bit 1 is set, bit 0 selects the next address-0 read: 1 for in-service, 0 for request.
  - When bit 6 is set, bit 5 loads `spec_mask`.
- R8: With poll not armed, a read at address 0 returns the selected in-service or request register, and a read at address 1 returns the mask.
- R9: An address-0 write with bits 4 and 3 clear is an end-of-interrupt word with its code in bits 7:5. Codes 1 and 5 clear in-service bit `hp_isr_line` when `hp_isr_valid` is 1, and do nothing otherwise. Code 5 also sets the rotation offset to that line plus 1, mod 8.
- R10: Code 3 clears the in-service bit numbered by bits 2:0. Code 7 does the same and also sets the rotation offset to that number plus 1, mod 8.
- R11: Codes 0 and 4 set `rot_aeoi` to bit 7. Code 6 sets the rotation offset to bits 2:0 plus 1, mod 8. Code 2 changes nothing.
- R12: A read while poll is armed returns one of two results, and disarms poll either way:
  - With `hp_req_valid` at 1, it returns `hp_req_line` and drives that bit in both `req_clr` and `isr_clr`.
  - With `hp_req_valid` at 0, it returns 0x07 with no clears.
- R13: Bits set on `isr_set` are in-service bits in the following cycle. When a clear and a set hit in the same cycle, the clear acts on the old value and the set bits survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address (0 or 1) |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid in the strobe cycle |
| req_vec | input | 8 | Current request register |
| isr_set | input | 8 | In-service set bits from the acknowledge path |
| hp_req_valid | input | 1 | An eligible request exists |
| hp_req_line | input | 3 | Best eligible request line |
| hp_isr_valid | input | 1 | An in-service bit exists |
| hp_isr_line | input | 3 | Best in-service line |
| imr_q | output | 8 | Mask register |
| isr_q | output | 8 | In-service register |
| vec_base | output | 8 | Vector base |
| rot_ofs | output | 3 | Rotation offset |
| sfn_mode | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| rot_aeoi | output | 1 | Rotate on automatic end of interrupt |
| spec_mask | output | 1 | Special mask flag |
| read_isr_sel | output | 1 | Address-0 read selects in-service |
| poll_armed | output | 1 | Poll armed for next read |
| single_mode | output | 1 | Single controller, no cascade word |
| need_mode_word | output | 1 | Mode word expected |
| init_state | output | 2 | Initialization state 0..3 |
| req_clr | output | 8 | Request bits to clear this cycle |
| isr_clr | output | 8 | In-service bits cleared this cycle |
| out_drop | output | 1 | Drop the output request this cycle |
| level_err | output | 1 | Level-sensitive mode was requested |

## Verification
The in-service register is both cleared by commands and set by the acknowledge path, and these can happen in the same cycle. The bench provokes the overlap by pulsing `isr_set` during the strobe of a non-specific and of a specific end-of-interrupt word. In the first case the cleared bit is the one being set again; in the second case the set bit is a different one. The expected result is the old value with the cleared bit removed, ORed with the set bits. A second overlap is a poll read that clears request and in-service bits while the same byte returns the line number. The line number and both clear vectors are sampled together inside the strobe cycle.

// File: rtl/picseq_pkg.sv
`timescale 1ns/1ps
package picseq_pkg;
    localparam int BYTE_W = 8;
    localparam int LINES  = 8;
    localparam int LINE_W = $clog2(LINES);

    typedef enum logic [1:0] {
        ST_READY        = 2'd0,
        ST_WAIT_BASE    = 2'd1,
        ST_WAIT_CASCADE = 2'd2,
        ST_WAIT_MODE    = 2'd3
    } init_st_e;

    typedef enum logic [2:0] {
        EOI_RAEOI_CLR   = 3'd0,
        EOI_NONSPEC     = 3'd1,
        EOI_NOP         = 3'd2,
        EOI_SPEC        = 3'd3,
        EOI_RAEOI_SET   = 3'd4,
        EOI_ROT_NONSPEC = 3'd5,
        EOI_SET_PRI     = 3'd6,
        EOI_ROT_SPEC    = 3'd7
    } eoi_code_e;
endpackage

// File: rtl/picseq_decode.sv
`timescale 1ns/1ps
module picseq_decode (
    input  logic       wr_en,
    input  logic       addr,
    input  logic [1:0] sel_bits,
    output logic       is_start,
    output logic       is_rdctl,
    output logic       is_eoi,
    output logic       is_port1
);
    always_comb begin
        is_start = wr_en && !addr && sel_bits[1];
        is_rdctl = wr_en && !addr && !sel_bits[1] && sel_bits[0];
        is_eoi   = wr_en && !addr && !sel_bits[1] && !sel_bits[0];
        is_port1 = wr_en && addr;
    end
endmodule

// File: rtl/picseq_initfsm.sv
`timescale 1ns/1ps
module picseq_initfsm
    import picseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     is_start,
    input  logic     is_port1,
    input  logic     bit_need,
    input  logic     bit_single,
    input  logic     bit_level,
    output init_st_e state,
    output logic     single_mode,
    output logic     need_mode_word,
    output logic     level_err
);
    init_st_e state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READY;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (is_start) begin
            state_nxt = ST_WAIT_BASE;
        end else if (is_port1) begin
            unique case (state)
                ST_READY:        state_nxt = ST_READY;
                ST_WAIT_BASE:    state_nxt = !single_mode ? ST_WAIT_CASCADE :
                                             (need_mode_word ? ST_WAIT_MODE : ST_READY);
                ST_WAIT_CASCADE: state_nxt = need_mode_word ? ST_WAIT_MODE : ST_READY;
                ST_WAIT_MODE:    state_nxt = ST_READY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            single_mode    <= 1'b0;
            need_mode_word <= 1'b0;
            level_err      <= 1'b0;
        end else if (is_start) begin
            single_mode    <= bit_single;
            need_mode_word <= bit_need;
            level_err      <= bit_level;
        end
    end
endmodule

// File: rtl/picseq_regs.sv
`timescale 1ns/1ps
module picseq_regs
    import picseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_start,
    input  logic              is_rdctl,
    input  logic              is_eoi,
    input  logic              is_port1,
    input  init_st_e          state,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [LINES-1:0]  isr_set,
    input  logic              hp_req_valid,
    input  logic [LINE_W-1:0] hp_req_line,
    input  logic              hp_isr_valid,
    input  logic [LINE_W-1:0] hp_isr_line,
    output logic [LINES-1:0]  imr_q,
    output logic [LINES-1:0]  isr_q,
    output logic [BYTE_W-1:0] vec_base,
    output logic [LINE_W-1:0] rot_ofs,
    output logic              sfn_mode,
    output logic              auto_eoi,
    output logic              rot_aeoi,
    output logic              spec_mask,
    output logic              read_isr_sel,
    output logic              poll_armed,
    output logic [LINES-1:0]  req_clr,
    output logic [LINES-1:0]  isr_clr
);
    localparam logic [BYTE_W-1:0] BASE_MASK = {BYTE_W{1'b1}} << LINE_W;

    eoi_code_e         code;
    logic [LINE_W-1:0] cmd_line;
    logic              rot_load;
    logic [LINE_W-1:0] rot_nxt;
    logic              poll_take;

    assign code      = eoi_code_e'(wr_data[BYTE_W-1 -: 3]);
    assign cmd_line  = wr_data[LINE_W-1:0];
    assign poll_take = rd_en && poll_armed && hp_req_valid;

    always_comb begin
        req_clr  = '0;
        isr_clr  = '0;
        rot_load = 1'b0;
        rot_nxt  = rot_ofs;
        if (is_start) begin
            req_clr = '1;
        end
        if (is_eoi) begin
            unique case (code)
                EOI_NONSPEC: begin
                    if (hp_isr_valid) isr_clr[hp_isr_line] = 1'b1;
                end
                EOI_ROT_NONSPEC: begin
                    if (hp_isr_valid) begin
                        isr_clr[hp_isr_line] = 1'b1;
                        rot_load = 1'b1;
                        rot_nxt  = hp_isr_line + LINE_W'(1);
                    end
                end
                EOI_SPEC: begin
                    isr_clr[cmd_line] = 1'b1;
                end
                EOI_ROT_SPEC: begin
                    isr_clr[cmd_line] = 1'b1;
                    rot_load = 1'b1;
                    rot_nxt  = cmd_line + LINE_W'(1);
                end
                EOI_SET_PRI: begin
                    rot_load = 1'b1;
                    rot_nxt  = cmd_line + LINE_W'(1);
                end
                EOI_RAEOI_CLR, EOI_RAEOI_SET, EOI_NOP: begin
                    rot_load = 1'b0;
                end
            endcase
        end
        if (poll_take) begin
            req_clr[hp_req_line] = 1'b1;
            isr_clr[hp_req_line] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imr_q        <= '0;
            isr_q        <= '0;
            vec_base     <= '0;
            rot_ofs      <= '0;
            sfn_mode     <= 1'b0;
            auto_eoi     <= 1'b0;
            rot_aeoi     <= 1'b0;
            spec_mask    <= 1'b0;
            read_isr_sel <= 1'b0;
            poll_armed   <= 1'b0;
        end else if (is_start) begin
            imr_q        <= '0;
            isr_q        <= '0;
            vec_base     <= '0;
            rot_ofs      <= '0;
            sfn_mode     <= 1'b0;
            auto_eoi     <= 1'b0;
            rot_aeoi     <= 1'b0;
            spec_mask    <= 1'b0;
            read_isr_sel <= 1'b0;
            poll_armed   <= 1'b0;
        end else begin
            isr_q <= (isr_q & ~isr_clr) | isr_set;
            if (is_port1) begin
                unique case (state)
                    ST_READY:        imr_q <= wr_data;
                    ST_WAIT_BASE:    vec_base <= wr_data & BASE_MASK;
                    ST_WAIT_CASCADE: vec_base <= vec_base;
                    ST_WAIT_MODE: begin
                        sfn_mode <= wr_data[4];
                        auto_eoi <= wr_data[1];
                    end
                endcase
            end
            if (rd_en && poll_armed) poll_armed <= 1'b0;
            if (is_rdctl) begin
                if (wr_data[2]) poll_armed   <= 1'b1;
                if (wr_data[1]) read_isr_sel <= wr_data[0];
                if (wr_data[6]) spec_mask    <= wr_data[5];
            end
            if (is_eoi && (code == EOI_RAEOI_CLR || code == EOI_RAEOI_SET))
                rot_aeoi <= wr_data[7];
            if (rot_load) rot_ofs <= rot_nxt;
        end
    end
endmodule

// File: rtl/picseq_rdmux.sv
`timescale 1ns/1ps
module picseq_rdmux
    import picseq_pkg::*;
(
    input  logic              addr,
    input  logic              poll_armed,
    input  logic              read_isr_sel,
    input  logic              hp_req_valid,
    input  logic [LINE_W-1:0] hp_req_line,
    input  logic [LINES-1:0]  req_vec,
    input  logic [LINES-1:0]  isr_q,
    input  logic [LINES-1:0]  imr_q,
    output logic [BYTE_W-1:0] rd_data
);
    localparam logic [BYTE_W-1:0] POLL_NONE = BYTE_W'(LINES - 1);

    always_comb begin
        if (poll_armed)
            rd_data = hp_req_valid ? BYTE_W'(hp_req_line) : POLL_NONE;
        else if (addr)
            rd_data = imr_q;
        else
            rd_data = read_isr_sel ? isr_q : req_vec;
    end
endmodule

// File: rtl/picseq_top.sv
`timescale 1ns/1ps
module picseq_top
    import picseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [LINES-1:0]  req_vec,
    input  logic [LINES-1:0]  isr_set,
    input  logic              hp_req_valid,
    input  logic [LINE_W-1:0] hp_req_line,
    input  logic              hp_isr_valid,
    input  logic [LINE_W-1:0] hp_isr_line,
    output logic [LINES-1:0]  imr_q,
    output logic [LINES-1:0]  isr_q,
    output logic [BYTE_W-1:0] vec_base,
    output logic [LINE_W-1:0] rot_ofs,
    output logic              sfn_mode,
    output logic              auto_eoi,
    output logic              rot_aeoi,
    output logic              spec_mask,
    output logic              read_isr_sel,
    output logic              poll_armed,
    output logic              single_mode,
    output logic              need_mode_word,
    output logic [1:0]        init_state,
    output logic [LINES-1:0]  req_clr,
    output logic [LINES-1:0]  isr_clr,
    output logic              out_drop,
    output logic              level_err
);
    logic     is_start, is_rdctl, is_eoi, is_port1;
    init_st_e state;

    picseq_decode u_dec (
        .wr_en    (wr_en),
        .addr     (addr),
        .sel_bits (wr_data[4:3]),
        .is_start (is_start),
        .is_rdctl (is_rdctl),
        .is_eoi   (is_eoi),
        .is_port1 (is_port1)
    );

    picseq_initfsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .is_start       (is_start),
        .is_port1       (is_port1),
        .bit_need       (wr_data[0]),
        .bit_single     (wr_data[1]),
        .bit_level      (wr_data[3]),
        .state          (state),
        .single_mode    (single_mode),
        .need_mode_word (need_mode_word),
        .level_err      (level_err)
    );

    picseq_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .is_start     (is_start),
        .is_rdctl     (is_rdctl),
        .is_eoi       (is_eoi),
        .is_port1     (is_port1),
        .state        (state),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .isr_set      (isr_set),
        .hp_req_valid (hp_req_valid),
        .hp_req_line  (hp_req_line),
        .hp_isr_valid (hp_isr_valid),
        .hp_isr_line  (hp_isr_line),
        .imr_q        (imr_q),
        .isr_q        (isr_q),
        .vec_base     (vec_base),
        .rot_ofs      (rot_ofs),
        .sfn_mode     (sfn_mode),
        .auto_eoi     (auto_eoi),
        .rot_aeoi     (rot_aeoi),
        .spec_mask    (spec_mask),
        .read_isr_sel (read_isr_sel),
        .poll_armed   (poll_armed),
        .req_clr      (req_clr),
        .isr_clr      (isr_clr)
    );

    picseq_rdmux u_rd (
        .addr         (addr),
        .poll_armed   (poll_armed),
        .read_isr_sel (read_isr_sel),
        .hp_req_valid (hp_req_valid),
        .hp_req_line  (hp_req_line),
        .req_vec      (req_vec),
        .isr_q        (isr_q),
        .imr_q        (imr_q),
        .rd_data      (rd_data)
    );

    assign init_state = state;
    assign out_drop   = is_start;
endmodule

// File: rtl/picseq_chk.sv
`timescale 1ns/1ps
module picseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       addr,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [7:0] isr_set,
    input logic [7:0] imr_q,
    input logic [7:0] isr_q,
    input logic [7:0] req_clr,
    input logic [1:0] init_state,
    input logic       poll_armed,
    input logic       hp_req_valid
);
    logic start_wr;
    assign start_wr = wr_en && !addr && wr_data[4];

    // R2
    start_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> (init_state == 2'd1 && imr_q == 8'h00 && isr_q == 8'h00));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |-> req_clr == 8'hFF);

    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && init_state == 2'd0) |=> imr_q == $past(wr_data));

    // R12
    poll_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_armed && !wr_en) |=> !poll_armed);

    // R12
    poll_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_armed && !hp_req_valid) |-> (rd_data == 8'h07 && req_clr == 8'h00));

    // R13
    isr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_set != 8'h00 && !start_wr) |=> ((isr_q & $past(isr_set)) == $past(isr_set)));
endmodule

bind picseq_top picseq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .isr_set      (isr_set),
    .imr_q        (imr_q),
    .isr_q        (isr_q),
    .req_clr      (req_clr),
    .init_state   (init_state),
    .poll_armed   (poll_armed),
    .hp_req_valid (hp_req_valid)
);

// File: tb/picseq_top_test.sv
`timescale 1ns/1ps
module picseq_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wr_data = '0, req_vec = '0, isr_set = '0;
    logic       hp_req_valid = 1'b0, hp_isr_valid = 1'b0;
    logic [2:0] hp_req_line = '0, hp_isr_line = '0;
    logic [7:0] rd_data, imr_q, isr_q, vec_base, req_clr, isr_clr;
    logic [2:0] rot_ofs;
    logic [1:0] init_state;
    logic       sfn_mode, auto_eoi, rot_aeoi, spec_mask, read_isr_sel, poll_armed;
    logic       single_mode, need_mode_word, out_drop, level_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] cap_rd, cap_rqc, cap_isc;
    logic       cap_drop;

    always #2.5 clk = ~clk;

    picseq_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .req_vec(req_vec), .isr_set(isr_set),
        .hp_req_valid(hp_req_valid), .hp_req_line(hp_req_line),
        .hp_isr_valid(hp_isr_valid), .hp_isr_line(hp_isr_line),
        .imr_q(imr_q), .isr_q(isr_q), .vec_base(vec_base), .rot_ofs(rot_ofs),
        .sfn_mode(sfn_mode), .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi),
        .spec_mask(spec_mask), .read_isr_sel(read_isr_sel), .poll_armed(poll_armed),
        .single_mode(single_mode), .need_mode_word(need_mode_word),
        .init_state(init_state), .req_clr(req_clr), .isr_clr(isr_clr),
        .out_drop(out_drop), .level_err(level_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d, input logic [7:0] set);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d; isr_set = set;
        #1;
        cap_rqc = req_clr; cap_isc = isr_clr; cap_drop = out_drop;
        @(negedge clk);
        wr_en = 1'b0; isr_set = '0;
    endtask

    task automatic rd(input logic a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        cap_rd = rd_data; cap_rqc = req_clr; cap_isc = isr_clr;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_set(input logic [7:0] set);
        @(negedge clk);
        isr_set = set;
        @(negedge clk);
        isr_set = '0;
    endtask

    task automatic t_reset;
        check("R1 init_state", init_state, 0);
        check("R1 imr", imr_q, 0);
        check("R1 isr", isr_q, 0);
        check("R1 vec_base", vec_base, 0);
        check("R1 flags", {sfn_mode, auto_eoi, rot_aeoi, spec_mask, poll_armed, rot_ofs}, 0);
    endtask

    task automatic t_init_cascade;
        wr(1'b0, 8'h11, 8'h00);
        check("R2 req_clr", cap_rqc, 8'hFF);
        check("R2 out_drop", cap_drop, 1);
        check("R2 state", init_state, 1);
        check("R2 need/single", {need_mode_word, single_mode}, 2'b10);
        wr(1'b1, 8'h4D, 8'h00);
        check("R3 vec_base", vec_base, 8'h48);
        check("R3 cascade next", init_state, 2);
        wr(1'b1, 8'h04, 8'h00);
        check("R4 next", init_state, 3);
        check("R4 vec_base kept", vec_base, 8'h48);
        check("R4 imr kept", imr_q, 8'h00);
        wr(1'b1, 8'h12, 8'h00);
        check("R5 sfn/aeoi", {sfn_mode, auto_eoi}, 2'b11);
        check("R5 next", init_state, 0);
    endtask

    task automatic t_init_single;
        wr(1'b0, 8'h1A, 8'h00);
        check("R2 level_err", level_err, 1);
        check("R2 mode flags cleared", {sfn_mode, auto_eoi}, 0);
        wr(1'b1, 8'h20, 8'h00);
        check("R3 single no word next", init_state, 0);
        wr(1'b0, 8'h13, 8'h00);
        check("R2 level_err cleared", level_err, 0);
        wr(1'b1, 8'h08, 8'h00);
        check("R3 single with word next", init_state, 3);
        wr(1'b1, 8'h00, 8'h00);
        check("R5 zero mode word", {sfn_mode, auto_eoi, init_state}, 0);
    endtask

    task automatic t_mask_read;
        wr(1'b1, 8'hA5, 8'h00);
        check("R6 imr", imr_q, 8'hA5);
        rd(1'b1);
        check("R8 read imr", cap_rd, 8'hA5);
    endtask

    task automatic t_ocw3;
        req_vec = 8'h81;
        pulse_set(8'h24);
        check("R13 isr set", isr_q, 8'h24);
        wr(1'b0, 8'h0A, 8'h00);
        rd(1'b0);
        check("R8 read req", cap_rd, 8'h81);
        wr(1'b0, 8'h0B, 8'h00);
        rd(1'b0);
        check("R8 read isr", cap_rd, 8'h24);
        wr(1'b0, 8'h08, 8'h00);
        rd(1'b0);
        check("R7 select kept without bit1", cap_rd, 8'h24);
        wr(1'b0, 8'h68, 8'h00);
        check("R7 spec_mask set", spec_mask, 1);
        wr(1'b0, 8'h28, 8'h00);
        check("R7 spec_mask kept without bit6", spec_mask, 1);
        wr(1'b0, 8'h48, 8'h00);
        check("R7 spec_mask cleared", spec_mask, 0);
        check("R7 poll not armed", poll_armed, 0);
    endtask

    task automatic t_eoi_nonspec;
        hp_isr_valid = 1'b1; hp_isr_line = 3'd2;
        wr(1'b0, 8'h20, 8'h00);
        check("R9 code1 clear", isr_q, 8'h20);
        check("R9 code1 ofs", rot_ofs, 0);
        hp_isr_line = 3'd5;
        wr(1'b0, 8'hA0, 8'h00);
        check("R9 code5 clear", isr_q, 8'h00);
        check("R9 code5 ofs", rot_ofs, 6);
        pulse_set(8'h01);
        hp_isr_valid = 1'b0;
        wr(1'b0, 8'h20, 8'h00);
        wr(1'b0, 8'hA0, 8'h00);
        check("R9 no valid line", isr_q, 8'h01);
        check("R9 no valid ofs", rot_ofs, 6);
    endtask

    task automatic t_eoi_spec;
        pulse_set(8'h88);
        wr(1'b0, 8'h63, 8'h00);
        check("R10 code3", isr_q, 8'h81);
        check("R10 code3 ofs", rot_ofs, 6);
        wr(1'b0, 8'hE7, 8'h00);
        check("R10 code7", isr_q, 8'h01);
        check("R10 code7 ofs wrap", rot_ofs, 0);
    endtask

    task automatic t_eoi_misc;
        wr(1'b0, 8'hC4, 8'h00);
        check("R11 code6 ofs", rot_ofs, 5);
        wr(1'b0, 8'h80, 8'h00);
        check("R11 code4", rot_aeoi, 1);
        wr(1'b0, 8'h00, 8'h00);
        check("R11 code0", rot_aeoi, 0);
        wr(1'b0, 8'h47, 8'h00);
        check("R11 code2 nop", {isr_q, 5'b0, rot_ofs, 7'b0, rot_aeoi}, {8'h01, 5'b0, 3'd5, 8'h00});
    endtask

    task automatic t_poll;
        pulse_set(8'h20);
        wr(1'b0, 8'h0C, 8'h00);
        check("R7 poll armed", poll_armed, 1);
        hp_req_valid = 1'b1; hp_req_line = 3'd5;
        rd(1'b0);
        check("R12 poll line", cap_rd, 8'h05);
        check("R12 req_clr", cap_rqc, 8'h20);
        check("R12 isr_clr", cap_isc, 8'h20);
        check("R12 disarm", poll_armed, 0);
        check("R12 isr after", isr_q, 8'h01);
        wr(1'b0, 8'h0C, 8'h00);
        hp_req_valid = 1'b0;
        rd(1'b1);
        check("R12 empty code", cap_rd, 8'h07);
        check("R12 empty no clear", cap_rqc, 8'h00);
        check("R12 empty disarm", poll_armed, 0);
    endtask

    task automatic t_collide;
        hp_isr_valid = 1'b1; hp_isr_line = 3'd0;
        wr(1'b0, 8'h20, 8'h01);
        check("R13 same bit clear+set", isr_q, 8'h01);
        wr(1'b0, 8'h60, 8'h02);
        check("R13 clear one set other", isr_q, 8'h02);
        hp_isr_valid = 1'b0;
    endtask

    task automatic t_reinit;
        wr(1'b0, 8'h11, 8'h00);
        check("R2 reinit clears", {imr_q, isr_q, 5'b0, rot_ofs}, 0);
        check("R2 reinit state", init_state, 1);
        check("R2 reinit drop", cap_drop, 1);
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init_cascade();
        t_init_single();
        t_mask_read();
        t_ocw3();
        t_eoi_nonspec();
        t_eoi_spec();
        t_eoi_misc();
        t_poll();
        t_collide();
        t_reinit();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule